// File: doc/BRIEF.md
# SD Transfer Abort Sequencer

This block ends a running SD data transfer, either an open-ended one or a multi-block one that must stop before its count runs out. Software posts one abort request. The request says whether the abort is asynchronous or synchronous, and whether the target is a memory card or an I/O card. For an I/O card the request also carries a function number. The block then chooses the abort command and its argument and presents them to a downstream command-issue interface. It raises a one-cycle done pulse once that interface accepts the command.

An asynchronous abort goes out as soon as the command-line inhibit flag is low. While the flag is high the request stays pending, with no time limit. A synchronous abort first raises a stop-at-block-gap request and waits for the block-gap event. After that event it applies the same inhibit gate and then issues the command.

A request that arrives while an abort is in progress does not change that abort. The block reports it with a one-cycle reject pulse.

Top module: `sd_abort_seq`

## Requirements
- R1: After reset, `cmd_valid`, `stop_gap_req`, `done` and `rejected` are all 0.
- R2: A memory-card abort (`req_io`=0) presents `cmd_index`=12, `cmd_arg`=0 and `cmd_busy`=1.
- R3: An I/O-card abort (`req_io`=1) presents `cmd_index`=52 and `cmd_busy`=0. `cmd_arg` is a write to register address 6 of function 0: bit 31 is 1, bits 25:9 hold 6, bits 7:0 hold the requested function number zero-extended, and every other bit is 0.
- R4: An asynchronous request (`req_sync`=0) accepted at clock edge E0 raises `cmd_valid` after the first edge Ek (k>=1) at which `cmd_inhibit` is sampled 0. An inhibit that stays high holds the request pending with no timeout.
- R5: A synchronous request (`req_sync`=1) accepted at E0 holds `stop_gap_req` high from E0 until the edge Eg that samples `gap_event`=1. `cmd_valid` stays low during that time. It rises after the first later edge that samples `cmd_inhibit`=0.
- R6: While `cmd_valid` is 1 and `cmd_ready` is 0, `cmd_valid`, `cmd_index`, `cmd_arg` and `cmd_busy` hold their values.
- R7: `done` pulses for exactly the one cycle after the edge that samples `cmd_valid` and `cmd_ready` both 1. `cmd_valid` drops at that same edge.
- R8: A `req_valid` sampled while an abort is in progress changes neither the command fields nor the timing of the current abort. `rejected` pulses in the following cycle.
- R9: `cmd_valid` and `stop_gap_req` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle abort request |
| req_sync | input | 1 | 1 = wait for a block gap first, 0 = asynchronous |
| req_io | input | 1 | 1 = I/O card target, 0 = memory card target |
| req_func | input | 3 | Function number placed in the I/O abort data |
| cmd_inhibit | input | 1 | Command line busy; blocks issue while 1 |
| gap_event | input | 1 | Data transfer has halted at a block gap |
| stop_gap_req | output | 1 | Request to halt the transfer at the next block gap |
| cmd_valid | output | 1 | Abort command offered to the issue interface |
| cmd_ready | input | 1 | Issue interface accepts the offered command |
| cmd_index | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_busy | output | 1 | Command expects a busy-signalling response |
| done | output | 1 | Abort command was accepted |
| rejected | output | 1 | A request arrived while busy and was dropped |

## Verification
The assertions check three things on every cycle. The block never offers a command and a stop request together. An offered command stays stable until it is accepted. `done` appears only after a handshake. They also check that a command is offered only after an edge that sampled inhibit low, and that the stop request holds until the gap event. Only the bench's scenarios can show which command and argument each target receives, and the exact cycle of issue for each pattern of inhibit and gap timing. They also show that a request arriving mid-abort leaves the running command untouched.

// File: rtl/sd_abort_pkg.sv
package sd_abort_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_GAP   = 2'd1,
      ST_INH   = 2'd2,
      ST_ISSUE = 2'd3
   } abort_st_e;
endpackage

// File: rtl/sd_abort_cmd.sv
module sd_abort_cmd #(
   parameter int IDX_W      = 6,
   parameter int ARG_W      = 32,
   parameter int FUNC_W     = 3,
   parameter int MEM_IDX    = 12,
   parameter int IO_IDX     = 52,
   parameter int IO_REG     = 6
) (
   input  logic              io_sel,
   input  logic [FUNC_W-1:0] func,
   output logic [IDX_W-1:0]  index,
   output logic [ARG_W-1:0]  arg,
   output logic              busy
);
   localparam int DATA_W   = 8;
   localparam int ADDR_LSB = 9;
   localparam int ADDR_W   = 17;
   localparam int WR_BIT   = ARG_W - 1;

   if (ARG_W != 32) begin : g_bad_arg
      $error("sd_abort_cmd: ARG_W must be 32");
   end
   if (FUNC_W < 1 || FUNC_W > DATA_W) begin : g_bad_func
      $error("sd_abort_cmd: FUNC_W must be 1..8");
   end
   if (MEM_IDX >= (1 << IDX_W) || IO_IDX >= (1 << IDX_W)) begin : g_bad_idx
      $error("sd_abort_cmd: index does not fit IDX_W");
   end

   logic [DATA_W-1:0] data_byte;

   if (FUNC_W == DATA_W) begin : g_full
      assign data_byte = func;
   end else begin : g_pad
      assign data_byte = {{(DATA_W-FUNC_W){1'b0}}, func};
   end

   always_comb begin
      arg = '0;
      if (io_sel) begin
         arg[WR_BIT]                   = 1'b1;
         arg[ADDR_LSB +: ADDR_W]       = ADDR_W'(IO_REG);
         arg[DATA_W-1:0]               = data_byte;
         index                         = IDX_W'(IO_IDX);
         busy                          = 1'b0;
      end else begin
         index                         = IDX_W'(MEM_IDX);
         busy                          = 1'b1;
      end
   end
endmodule

// File: rtl/sd_abort_fsm.sv
module sd_abort_fsm
   import sd_abort_pkg::*;
#(
   parameter int FUNC_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_sync,
   input  logic              req_io,
   input  logic [FUNC_W-1:0] req_func,
   input  logic              cmd_inhibit,
   input  logic              gap_event,
   input  logic              cmd_ready,
   output logic              stop_gap_req,
   output logic              cmd_valid,
   output logic              io_sel,
   output logic [FUNC_W-1:0] func,
   output logic              done,
   output logic              rejected
);
   abort_st_e st_q;
   logic      io_q;
   logic [FUNC_W-1:0] func_q;
   logic      done_q, rej_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         io_q   <= 1'b0;
         func_q <= '0;
         done_q <= 1'b0;
         rej_q  <= 1'b0;
      end else begin
         done_q <= (st_q == ST_ISSUE) && cmd_ready;
         rej_q  <= req_valid && (st_q != ST_IDLE);
         case (st_q)
            ST_IDLE: if (req_valid) begin
               io_q   <= req_io;
               func_q <= req_func;
               st_q   <= req_sync ? ST_GAP : ST_INH;
            end
            ST_GAP:   if (gap_event)    st_q <= ST_INH;
            ST_INH:   if (!cmd_inhibit) st_q <= ST_ISSUE;
            ST_ISSUE: if (cmd_ready)    st_q <= ST_IDLE;
            default:                    st_q <= ST_IDLE;
         endcase
      end
   end

   assign stop_gap_req = (st_q == ST_GAP);
   assign cmd_valid    = (st_q == ST_ISSUE);
   assign io_sel       = io_q;
   assign func         = func_q;
   assign done         = done_q;
   assign rejected     = rej_q;

   // R9
   excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({stop_gap_req, cmd_valid}));
   // R4
   issue_after_inh_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_valid) |-> !$past(cmd_inhibit));
   // R5
   gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_gap_req && !gap_event) |=> stop_gap_req);
   // R6
   hold_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(io_sel) && $stable(func)));
   // R7
   done_after_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(cmd_valid && cmd_ready));
   // R7
   drop_after_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready) |=> !cmd_valid);
endmodule

// File: rtl/sd_abort_seq.sv
module sd_abort_seq #(
   parameter int IDX_W   = 6,
   parameter int ARG_W   = 32,
   parameter int FUNC_W  = 3,
   parameter int MEM_IDX = 12,
   parameter int IO_IDX  = 52,
   parameter int IO_REG  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_sync,
   input  logic              req_io,
   input  logic [FUNC_W-1:0] req_func,
   input  logic              cmd_inhibit,
   input  logic              gap_event,
   output logic              stop_gap_req,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic [IDX_W-1:0]  cmd_index,
   output logic [ARG_W-1:0]  cmd_arg,
   output logic              cmd_busy,
   output logic              done,
   output logic              rejected
);
   logic              io_sel;
   logic [FUNC_W-1:0] func;

   sd_abort_fsm #(.FUNC_W(FUNC_W)) i_fsm (
      .clk, .rst_n, .req_valid, .req_sync, .req_io, .req_func,
      .cmd_inhibit, .gap_event, .cmd_ready,
      .stop_gap_req, .cmd_valid, .io_sel, .func, .done, .rejected
   );

   sd_abort_cmd #(
      .IDX_W(IDX_W), .ARG_W(ARG_W), .FUNC_W(FUNC_W),
      .MEM_IDX(MEM_IDX), .IO_IDX(IO_IDX), .IO_REG(IO_REG)
   ) i_cmd (
      .io_sel, .func, .index(cmd_index), .arg(cmd_arg), .busy(cmd_busy)
   );

   // R2
   mem_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_index == IDX_W'(MEM_IDX)) |-> (cmd_busy && cmd_arg == '0));
   // R3
   io_nobusy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_index == IDX_W'(IO_IDX)) |-> (!cmd_busy && cmd_arg[ARG_W-1]));
   // R6
   arg_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_ready) |=> ($stable(cmd_arg) && $stable(cmd_index) && $stable(cmd_busy)));
endmodule

// File: tb/test_sd_abort_seq.sv
module test_sd_abort_seq;
   localparam int CLK_PER = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 0, req_sync = 0, req_io = 0;
   logic [2:0] req_func = '0;
   logic cmd_inhibit = 0, gap_event = 0, cmd_ready = 0;
   logic stop_gap_req, cmd_valid, cmd_busy, done, rejected;
   logic [5:0]  cmd_index;
   logic [31:0] cmd_arg;

   int n_cmp = 0;
   int n_bad = 0;

   always #(CLK_PER/2) clk = ~clk;

   sd_abort_seq i_sd_abort_seq (
      .clk, .rst_n, .req_valid, .req_sync, .req_io, .req_func,
      .cmd_inhibit, .gap_event, .stop_gap_req, .cmd_valid, .cmd_ready,
      .cmd_index, .cmd_arg, .cmd_busy, .done, .rejected
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic run_one(input bit s, input bit io, input int f, input int d);
      int exp_v, g;
      logic [31:0] exp_arg;
      g       = d + 1;
      exp_v   = s ? g + 1 : ((d < 1) ? 1 : d);
      exp_arg = io ? (32'h8000_0000 | (32'd6 << 9) | 32'(f)) : 32'h0;
      @(negedge clk);
      req_valid = 1; req_sync = s; req_io = io; req_func = 3'(f);
      cmd_inhibit = !s && (d > 0); gap_event = 0; cmd_ready = 0;
      @(posedge clk);   // E0
      for (int m = 0; m <= exp_v + 2; m++) begin
         @(negedge clk);
         // observe state after E_m
         chk("R9 excl", {31'b0, stop_gap_req & cmd_valid}, 32'h0);
         if (s) chk("R5 stop_gap_req", {31'b0, stop_gap_req}, {31'b0, (m < g)});
         else   chk("R4 stop_gap_req", {31'b0, stop_gap_req}, 32'h0);
         chk(s ? "R5 cmd_valid" : "R4 cmd_valid", {31'b0, cmd_valid},
             {31'b0, (m == exp_v) || (m == exp_v + 1 && 1'b0) || (m > exp_v && m < exp_v + 1)});
         chk("R8 rejected", {31'b0, rejected}, {31'b0, (m == 1)});
         chk("R7 done", {31'b0, done}, {31'b0, (m == exp_v + 1)});
         if (m == exp_v) begin
            chk(io ? "R3 index" : "R2 index", 32'(cmd_index), io ? 32'd52 : 32'd12);
            chk(io ? "R3 arg" : "R2 arg", cmd_arg, exp_arg);
            chk(io ? "R3 busy" : "R2 busy", {31'b0, cmd_busy}, {31'b0, !io});
         end
         // inputs for E_{m+1}
         req_valid   = (m == 0);
         req_sync    = (m == 0) ? !s : s;
         req_io      = (m == 0) ? !io : io;
         req_func    = (m == 0) ? ~3'(f) : 3'(f);
         cmd_inhibit = !s && (m + 1 < d);
         gap_event   = s && (m + 1 == g);
         cmd_ready   = (m == exp_v);
      end
      cmd_ready = 0; req_valid = 0; gap_event = 0; cmd_inhibit = 0;
   endtask

   // R6: hold command while ready stays low, memory card
   task automatic run_hold();
      @(negedge clk);
      req_valid = 1; req_sync = 0; req_io = 0; cmd_inhibit = 0; cmd_ready = 0;
      @(negedge clk);
      req_valid = 0;
      @(negedge clk);
      for (int k = 0; k < 4; k++) begin
         chk("R6 valid held", {31'b0, cmd_valid}, 32'h1);
         chk("R6 index held", 32'(cmd_index), 32'd12);
         @(negedge clk);
      end
      cmd_ready = 1;
      @(negedge clk);
      cmd_ready = 0;
      chk("R7 done after hold", {31'b0, done}, 32'h1);
      chk("R7 valid dropped", {31'b0, cmd_valid}, 32'h0);
      @(negedge clk);
      chk("R7 done one cycle", {31'b0, done}, 32'h0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 cmd_valid", {31'b0, cmd_valid}, 32'h0);
      chk("R1 stop_gap_req", {31'b0, stop_gap_req}, 32'h0);
      chk("R1 done", {31'b0, done}, 32'h0);
      chk("R1 rejected", {31'b0, rejected}, 32'h0);
      rst_n = 1;
      for (int s = 0; s < 2; s++)
         for (int io = 0; io < 2; io++)
            for (int f = 0; f < 8; f++)
               for (int d = 0; d < 4; d++)
                  run_one(s[0], io[0], f, d);
      run_hold();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PER * 20000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule